// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block gathers the level-sensitive interrupt pins of every device on a PCI bus and folds them onto a 16-line legacy interrupt bus. Each device pin is first steered onto one of four shared interrupt lines (A, B, C, D; index 0 to 3). The choice depends on the slot number of the device through a fixed swizzle. Each shared line then has a byte-wide route register that names the legacy IRQ it drives. Lines that name the same IRQ are wire-ORed onto it.

Software programs the route registers through a small write port. A route value of 16 or more parks a line, so it drives nothing. The output vector is a pure function of the current pin levels and the current route registers. A pin change reaches the output in the same cycle. A route write takes effect right after the clock edge that captures it. The interrupt controller that consumes the vector and any edge conversion sit outside this block.

Top module: `pirq_router`

## Requirements
- R1: After reset the route registers hold 10, 10, 11, 11 for lines A, B, C, D. With every line active, only legacy IRQs 10 and 11 are high (`legacy_irq` = 16'h0C00).
- R2: A write with `rt_wr_en` high loads `rt_wr_data` into the route register of line `rt_wr_sel` (0=A, 1=B, 2=C, 3=D) at the clock edge. From that edge on, the line drives the new IRQ and no longer drives the old one.
- R3: A route value of 16 or more (up to 255) stops that line from driving any legacy IRQ.
- R4: Each `legacy_irq[k]` is the OR of every shared line whose route register equals k. An IRQ shared by two lines stays high while either line is active.
- R5: Device pins are indexed as `dev_pin_lvl[slot*4 + pin]`, with pin 0..3 meaning INTA..INTD. In slot 10 every pin maps to line D (3). In slot 11 every pin maps to line B (1). In slot 12 every pin maps to line C (2).
- R6: In slots 18 to 21, pin n maps to line ((slot - 18) + n) mod 4.
- R7: In every other slot, pin n maps to line n.
- R8: The output reacts combinationally to pin levels. A pin change is visible on `legacy_irq` in the same cycle, with no clock edge in between.
- R9: Each shared line is the OR of all device pins mapped to it. With no pin asserted, `legacy_irq` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the route registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pin_lvl | input | SLOTS*4 | Device interrupt levels, bit slot*4+pin |
| rt_wr_en | input | 1 | Route register write strobe |
| rt_wr_sel | input | 2 | Line selected for the write (0=A .. 3=D) |
| rt_wr_data | input | 8 | New route value |
| legacy_irq | output | 16 | Legacy IRQ level vector |

## Verification
The block has two latencies. Pin-level changes reach `legacy_irq` in zero cycles. Route writes take effect one edge after the strobe. The bench changes pins half a period away from the rising edge and compares a nanosecond later, before any edge. For writes, it checks once just before the capturing edge, when the old routing must still hold. It checks again at the following falling edge, when the new routing must be in place. The swizzle tests sweep every pin of the special slots and compare against a slot-to-line model written from the requirements.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int SLOTS = 32,
  parameter int PINS  = 4,
  parameter int NIRQ  = 16,
  parameter int RW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS*PINS-1:0] dev_pin_lvl,
  input  logic                  rt_wr_en,
  input  logic [1:0]            rt_wr_sel,
  input  logic [RW-1:0]         rt_wr_data,
  output logic [NIRQ-1:0]       legacy_irq
);
  localparam int LINES = 4;

  function automatic logic [1:0] pick_line(int slot, int pin);
    if (slot == 10)                  return 2'd3;
    else if (slot == 11)             return 2'd1;
    else if (slot == 12)             return 2'd2;
    else if (slot >= 18 && slot <= 21) return 2'((slot - 18 + pin) % LINES);
    else                             return 2'(pin % LINES);
  endfunction

  logic [LINES-1:0][RW-1:0] route_q;
  logic [LINES-1:0]         line_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q[0] <= RW'(10);
      route_q[1] <= RW'(10);
      route_q[2] <= RW'(11);
      route_q[3] <= RW'(11);
    end else if (rt_wr_en) begin
      route_q[rt_wr_sel] <= rt_wr_data;
    end
  end

  always_comb begin
    line_lvl = '0;
    for (int s = 0; s < SLOTS; s++)
      for (int p = 0; p < PINS; p++)
        if (dev_pin_lvl[s*PINS+p]) line_lvl[pick_line(s, p)] = 1'b1;
  end

  always_comb begin
    legacy_irq = '0;
    for (int k = 0; k < NIRQ; k++)
      for (int l = 0; l < LINES; l++)
        if (line_lvl[l] && route_q[l] == RW'(k)) legacy_irq[k] = 1'b1;
  end
endmodule

module pirq_router_chk #(
  parameter int SLOTS = 32,
  parameter int PINS  = 4,
  parameter int NIRQ  = 16,
  parameter int RW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLOTS*PINS-1:0] dev_pin_lvl,
  input logic                  rt_wr_en,
  input logic [1:0]            rt_wr_sel,
  input logic [RW-1:0]         rt_wr_data,
  input logic [3:0][RW-1:0]    route_q,
  input logic [3:0]            line_lvl,
  input logic [NIRQ-1:0]       legacy_irq
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1
  reset_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (route_q[0] == RW'(10) && route_q[1] == RW'(10) &&
                route_q[2] == RW'(11) && route_q[3] == RW'(11)));

  // R2
  wr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_wr_en |=> route_q[$past(rt_wr_sel)] == $past(rt_wr_data));

  // R3
  parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[0] >= RW'(NIRQ) && line_lvl == 4'b0001) |-> legacy_irq == '0);

  // R4
  fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(legacy_irq) <= $countones(line_lvl));

  // R5
  slot10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_pin_lvl[10*PINS +: PINS]) |-> line_lvl[3]);

  // R6
  swizzle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pin_lvl[19*PINS+3] |-> line_lvl[0]);

  // R7
  direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_pin_lvl[0*PINS+2] |-> line_lvl[2]);

  // R8
  live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl[0] && route_q[0] < RW'(NIRQ)) |-> legacy_irq[route_q[0][3:0]]);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_pin_lvl == '0) |-> (line_lvl == '0 && legacy_irq == '0));
endmodule

bind pirq_router pirq_router_chk #(.SLOTS(SLOTS), .PINS(PINS), .NIRQ(NIRQ), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_pin_lvl(dev_pin_lvl), .rt_wr_en(rt_wr_en),
  .rt_wr_sel(rt_wr_sel), .rt_wr_data(rt_wr_data), .route_q(route_q),
  .line_lvl(line_lvl), .legacy_irq(legacy_irq)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  localparam int SLOTS = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SLOTS*4-1:0] dev_pin_lvl = '0;
  logic rt_wr_en = 1'b0;
  logic [1:0] rt_wr_sel = '0;
  logic [7:0] rt_wr_data = '0;
  logic [15:0] legacy_irq;
  int vecs = 0, errs = 0;
  logic [7:0] mroute [4];

  always #2.5 clk = ~clk;

  pirq_router #(.SLOTS(SLOTS)) u_pirq_router (
    .clk(clk), .rst_n(rst_n), .dev_pin_lvl(dev_pin_lvl), .rt_wr_en(rt_wr_en),
    .rt_wr_sel(rt_wr_sel), .rt_wr_data(rt_wr_data), .legacy_irq(legacy_irq)
  );

  function automatic int exp_line(int s, int p);
    case (s)
      10: return 3;
      11: return 1;
      12: return 2;
      18, 19, 20, 21: return (s - 18 + p) & 3;
      default: return p;
    endcase
  endfunction

  function automatic logic [15:0] model(logic [SLOTS*4-1:0] d);
    logic [3:0] ln = '0;
    logic [15:0] e = '0;
    for (int s = 0; s < SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (d[s*4+p]) ln[exp_line(s, p)] = 1'b1;
    for (int l = 0; l < 4; l++)
      if (ln[l] && mroute[l] < 8'd16) e[mroute[l][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    vecs++;
    if (legacy_irq !== exp) begin
      errs++;
      $display("FAIL %s: legacy_irq=%h expected %h", req, legacy_irq, exp);
    end
  endtask

  task automatic pins(logic [SLOTS*4-1:0] d);
    @(negedge clk);
    dev_pin_lvl = d;
    #1;
  endtask

  task automatic wr(int sel, logic [7:0] v);
    @(negedge clk);
    rt_wr_en = 1'b1; rt_wr_sel = 2'(sel); rt_wr_data = v;
    @(negedge clk);
    rt_wr_en = 1'b0;
    mroute[sel] = v;
    #1;
  endtask

  task automatic t_reset;
    pins('0);
    chk("R9 idle", 16'h0000);
    pins(128'hF);
    chk("R1 reset routes", 16'h0C00);
    pins(128'h1);
    chk("R1 line A to 10", 16'h0400);
    pins(128'h8);
    chk("R1 line D to 11", 16'h0800);
  endtask

  task automatic t_direct;
    wr(0, 8'd3); wr(1, 8'd4); wr(2, 8'd5); wr(3, 8'd6);
    for (int p = 0; p < 4; p++) begin
      logic [SLOTS*4-1:0] d = '0;
      d[5*4+p] = 1'b1;
      pins(d);
      chk("R7 slot5 direct", 16'(1) << (3 + p));
    end
    pins(128'h1 << (31*4+1));
    chk("R7 slot31 pinB", 16'h0010);
  endtask

  task automatic t_fixed;
    for (int s = 10; s <= 12; s++)
      for (int p = 0; p < 4; p++) begin
        logic [SLOTS*4-1:0] d = '0;
        d[s*4+p] = 1'b1;
        pins(d);
        chk("R5 fixed slot", (s == 10) ? 16'h0040 : (s == 11) ? 16'h0010 : 16'h0020);
      end
  endtask

  task automatic t_swizzle;
    for (int s = 18; s <= 21; s++)
      for (int p = 0; p < 4; p++) begin
        logic [SLOTS*4-1:0] d = '0;
        d[s*4+p] = 1'b1;
        pins(d);
        chk("R6 swizzle", model(d));
      end
    pins(128'h1 << (19*4+3));
    chk("R6 slot19 pinD to A", 16'h0008);
  endtask

  task automatic t_share;
    wr(0, 8'd7); wr(1, 8'd7);
    pins(128'h3);
    chk("R4 shared both", 16'h0080);
    pins(128'h2);
    chk("R4 shared one left", 16'h0080);
    pins((128'h1 << (5*4)) | (128'h1 << (6*4)));
    chk("R9 two pins one line", 16'h0080);
    pins(128'h1 << (6*4));
    chk("R9 one pin left", 16'h0080);
    pins('0);
    chk("R4 shared none", 16'h0000);
  endtask

  task automatic t_disable;
    wr(0, 8'd16);
    pins(128'h1);
    chk("R3 route 16", 16'h0000);
    wr(0, 8'd255);
    chk("R3 route 255", 16'h0000);
    wr(0, 8'd15);
    chk("R3 route 15 active", 16'h8000);
    wr(0, 8'd0);
    chk("R2 route 0", 16'h0001);
  endtask

  task automatic t_live;
    wr(0, 8'd3);
    pins(128'h1);
    chk("R8 same cycle assert", 16'h0008);
    @(negedge clk);
    rt_wr_en = 1'b1; rt_wr_sel = 2'd0; rt_wr_data = 8'd9;
    #1;
    chk("R2 before edge", 16'h0008);
    @(negedge clk);
    rt_wr_en = 1'b0; mroute[0] = 8'd9;
    #1;
    chk("R2 after edge", 16'h0200);
    @(posedge clk);
    #1;
    dev_pin_lvl = '0;
    #0.5;
    chk("R8 same cycle deassert", 16'h0000);
  endtask

  initial begin
    mroute[0] = 8'd10; mroute[1] = 8'd10; mroute[2] = 8'd11; mroute[3] = 8'd11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_fixed();
    t_swizzle();
    t_share();
    t_disable();
    t_live();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule